// File: doc/BRIEF.md
# Gap-Delimited Ping-Pong Command Receiver

This block takes an asynchronous serial line carrying command messages and collects the bytes of each message into one of two equal receive banks. No length field marks where a message stops. A message is taken as complete once the line has stayed idle for a programmable number of clock cycles after the last stop bit. When that happens, the bank that was filling is handed to the consumer and reception continues in the other bank. Senders leave a wide pause between commands (tens of milliseconds against a 2 ms idle threshold), so each command causes exactly one hand-over.

The consumer sees a ready flag, the byte count of the completed message and a four-bit status word. It reads bytes through an address port into the bank it holds and releases that bank with a one-cycle acknowledge. The status word gives the bank index and three flags: a byte arrived with a bad stop bit, bytes were dropped because the bank was full, or a newer message replaced one that had not been acknowledged. The consumer checks these flags before it uses the message.

Characters use 8 data bits, sent least significant bit first, with no parity and one stop bit. The line is sampled at 16 times the bit rate. With the default parameters and a 125 MHz clock the line runs near 56 kbaud, each bank holds 1024 bytes and the idle threshold is 2 ms.

Top module: `cmd_rx_top`

## Requirements
- R1: After reset, ready_o is 0, msg_len_o is 0 and status_o is 4'b0000.
- R2: Each 8N1 character (start bit low, 8 data bits LSB first, stop bit high, sampled at 16 times the bit rate) is stored in arrival order at bank addresses 0, 1, 2 and so on. rd_data_o shows the byte at rd_addr_i of the held bank one clock after the address is applied.
- R3: ready_o rises only after the line has been idle for GAP_CYCLES clocks since the last stop-bit sample, with no start bit in progress. Idle pauses shorter than GAP_CYCLES between bytes do not split a message.
- R4: While the filling bank is empty, an idle line never causes a hand-over, so ready_o stays 0.
- R5: Each hand-over passes the filling bank to the consumer and switches reception to the other bank. status_o[2] gives the index of the held bank: 0 for the first message after reset, then alternating 1, 0, 1, and so on.
- R6: msg_len_o equals the number of bytes stored in the held bank.
- R7: Bytes that arrive after BUF_DEPTH bytes are dropped. msg_len_o is then BUF_DEPTH, status_o[1] is set and the stored bytes are unchanged.
- R8: A character whose stop bit samples low sets status_o[0] for its message and is still stored. The flag does not carry over to the next message.
- R9: An ack_i pulse while ready_o is high clears ready_o and status_o bits 0, 1 and 3 on the next clock.
- R10: If a message completes while ready_o is still high, the new message replaces the held one and status_o[3] is set.
- R11: A low pulse shorter than half a bit time on an idle line is rejected and stores no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| ack_i | input | 1 | Consumer releases the held bank |
| rd_addr_i | input | $clog2(BUF_DEPTH) | Byte address into the held bank |
| rd_data_o | output | 8 | Byte read from the held bank, one clock after the address |
| ready_o | output | 1 | A completed message is held |
| msg_len_o | output | $clog2(BUF_DEPTH+1) | Byte count of the held message |
| status_o | output | 4 | [3] replaced unread, [2] bank index, [1] overflow, [0] framing error |

## Verification
A gap timer that runs too long, or that keeps running during a start bit, shows at the ports in the message itself. ready_o rises late or early, measured from the last stop bit, or a slow stream of bytes is split into two messages with short lengths. A bank-select register out of step shows within one message: status_o[2] fails to alternate, or the bytes read back belong to the wrong command. Flags that are not cleared on the hand-over, or a write counter that is not reset, show on the very next message as a stale error bit or a wrong msg_len_o.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic replaced;
    logic bank;
    logic overflow;
    logic frame_err;
  } rx_status_t;

endpackage

// File: rtl/cmd_rx_uart.sv
module cmd_rx_uart
  import cmd_rx_pkg::*;
#(
  parameter int CLK_PER_TICK = 140,
  parameter int OVERSAMPLE   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic       busy_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       ferr_o
);

  localparam int TW  = $clog2(CLK_PER_TICK);
  localparam int OW  = $clog2(OVERSAMPLE);
  localparam logic [TW-1:0] TICK_LAST = TW'(CLK_PER_TICK - 1);
  localparam logic [OW-1:0] OS_LAST   = OW'(OVERSAMPLE - 1);
  localparam logic [OW-1:0] OS_MID    = OW'(OVERSAMPLE / 2 - 1);

  logic [1:0]    rx_q;
  logic          rx_s;
  logic [TW-1:0] tick_cnt;
  logic          tick;
  logic [OW-1:0] os_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;
  rx_state_e     st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 2'b11;
    else         rx_q <= {rx_q[0], rx_i};
  end
  assign rx_s = rx_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tick_cnt <= '0;
    else if (tick_cnt == TICK_LAST) tick_cnt <= '0;
    else                        tick_cnt <= tick_cnt + 1'b1;
  end
  assign tick = (tick_cnt == TICK_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= RX_IDLE;
      os_cnt     <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      byte_vld_o <= 1'b0;
      ferr_o     <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (!rx_s) begin
            st     <= RX_START;
            os_cnt <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (os_cnt == OS_MID) begin
              // confirm start at mid-bit, else treat as glitch
              st      <= rx_s ? RX_IDLE : RX_DATA;
              os_cnt  <= '0;
              bit_idx <= '0;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (os_cnt == OS_LAST) begin
              shreg  <= {rx_s, shreg[7:1]};
              os_cnt <= '0;
              if (bit_idx == 3'd7) st <= RX_STOP;
              else                 bit_idx <= bit_idx + 1'b1;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (os_cnt == OS_LAST) begin
              byte_vld_o <= 1'b1;
              ferr_o     <= ~rx_s;
              st         <= RX_IDLE;
              os_cnt     <= '0;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign busy_o = (st != RX_IDLE);
  assign byte_o = shreg;

endmodule

// File: rtl/cmd_rx_gap_timer.sv
module cmd_rx_gap_timer #(
  parameter int GAP_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic byte_vld_i,
  input  logic nonempty_i,
  output logic swap_o
);

  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

  logic [GW-1:0] idle_cnt;
  logic          hold;

  assign hold = byte_vld_i | busy_i | ~nonempty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   idle_cnt <= '0;
    else if (hold)                 idle_cnt <= '0;
    else if (idle_cnt == GAP_LAST) idle_cnt <= '0;
    else                           idle_cnt <= idle_cnt + 1'b1;
  end

  assign swap_o = ~hold & (idle_cnt == GAP_LAST);

endmodule

// File: rtl/cmd_rx_pingpong.sv
module cmd_rx_pingpong
  import cmd_rx_pkg::*;
#(
  parameter int BUF_DEPTH = 1024,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int LW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          ferr_i,
  input  logic          swap_i,
  input  logic          ack_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          nonempty_o,
  output logic          fill_sel_o,
  output logic          ready_o,
  output logic [LW-1:0] len_o,
  output rx_status_t    status_o
);

  localparam logic [LW-1:0] FULL = LW'(BUF_DEPTH);

  logic          fill_sel;
  logic          rd_sel;
  logic [LW-1:0] wr_cnt;
  logic          acc_ferr;
  logic          acc_ovf;
  logic          st_ferr;
  logic          st_ovf;
  logic          st_rep;
  logic          room;
  logic          we;

  assign room = (wr_cnt < FULL);
  assign we   = byte_vld_i & room;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [BUF_DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk_i) begin
      if (we && (fill_sel == b[0])) mem[wr_cnt[AW-1:0]] <= byte_i;
      q <= mem[rd_addr_i];
    end
  end

  assign rd_data_o = rd_sel ? g_bank[1].q : g_bank[0].q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_sel <= 1'b0;
      rd_sel   <= 1'b0;
      wr_cnt   <= '0;
      acc_ferr <= 1'b0;
      acc_ovf  <= 1'b0;
      ready_o  <= 1'b0;
      len_o    <= '0;
      st_ferr  <= 1'b0;
      st_ovf   <= 1'b0;
      st_rep   <= 1'b0;
    end else if (swap_i) begin
      rd_sel   <= fill_sel;
      fill_sel <= ~fill_sel;
      len_o    <= wr_cnt;
      st_ferr  <= acc_ferr;
      st_ovf   <= acc_ovf;
      // an ack in the same cycle was for the old message
      st_rep   <= ready_o & ~ack_i;
      ready_o  <= 1'b1;
      wr_cnt   <= '0;
      acc_ferr <= 1'b0;
      acc_ovf  <= 1'b0;
    end else begin
      if (ack_i && ready_o) begin
        ready_o <= 1'b0;
        st_ferr <= 1'b0;
        st_ovf  <= 1'b0;
        st_rep  <= 1'b0;
      end
      if (byte_vld_i) begin
        if (room) wr_cnt <= wr_cnt + 1'b1;
        else      acc_ovf <= 1'b1;
        if (ferr_i) acc_ferr <= 1'b1;
      end
    end
  end

  assign nonempty_o = (wr_cnt != '0);
  assign fill_sel_o = fill_sel;
  assign status_o   = '{replaced: st_rep, bank: rd_sel, overflow: st_ovf, frame_err: st_ferr};

endmodule

// File: rtl/cmd_rx_top.sv
module cmd_rx_top
  import cmd_rx_pkg::*;
#(
  parameter int CLK_PER_TICK = 140,
  parameter int OVERSAMPLE   = 16,
  parameter int GAP_CYCLES   = 250000,
  parameter int BUF_DEPTH    = 1024
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rx_i,
  input  logic                           ack_i,
  input  logic [$clog2(BUF_DEPTH)-1:0]   rd_addr_i,
  output logic [7:0]                     rd_data_o,
  output logic                           ready_o,
  output logic [$clog2(BUF_DEPTH+1)-1:0] msg_len_o,
  output logic [3:0]                     status_o
);

  localparam int LW = $clog2(BUF_DEPTH + 1);

  logic       rx_busy;
  logic       byte_vld;
  logic [7:0] rx_byte;
  logic       rx_ferr;
  logic       swap;
  logic       buf_nonempty;
  logic       fill_sel;
  rx_status_t status;

  cmd_rx_uart #(
    .CLK_PER_TICK(CLK_PER_TICK),
    .OVERSAMPLE  (OVERSAMPLE)
  ) u_uart (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_i),
    .busy_o    (rx_busy),
    .byte_vld_o(byte_vld),
    .byte_o    (rx_byte),
    .ferr_o    (rx_ferr)
  );

  cmd_rx_gap_timer #(
    .GAP_CYCLES(GAP_CYCLES)
  ) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (rx_busy),
    .byte_vld_i(byte_vld),
    .nonempty_i(buf_nonempty),
    .swap_o    (swap)
  );

  cmd_rx_pingpong #(
    .BUF_DEPTH(BUF_DEPTH)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_vld_i(byte_vld),
    .byte_i    (rx_byte),
    .ferr_i    (rx_ferr),
    .swap_i    (swap),
    .ack_i     (ack_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .nonempty_o(buf_nonempty),
    .fill_sel_o(fill_sel),
    .ready_o   (ready_o),
    .len_o     (msg_len_o),
    .status_o  (status)
  );

  assign status_o = status;

endmodule

// File: rtl/cmd_rx_chk.sv
module cmd_rx_chk #(
  parameter int BUF_DEPTH = 1024,
  parameter int LW        = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic          ready_o,
  input logic [LW-1:0] msg_len_o,
  input logic [3:0]    status_o,
  input logic          swap_i,
  input logic          busy_i,
  input logic          nonempty_i,
  input logic          fill_sel_i
);

  localparam logic [LW-1:0] FULL = LW'(BUF_DEPTH);

  // R3
  gap_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |-> !busy_i);

  // R4
  empty_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |-> nonempty_i);

  // R5
  bank_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> (status_o[2] == $past(fill_sel_i)));

  // R6
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (msg_len_o <= FULL));

  // R7
  ovf_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && status_o[1]) |-> (msg_len_o == FULL));

  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ready_o && !swap_i) |=> !ready_o);

  // R10
  replace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && ready_o && !ack_i) |=> (ready_o && status_o[3]));

endmodule

bind cmd_rx_top cmd_rx_chk #(
  .BUF_DEPTH(BUF_DEPTH),
  .LW       (LW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_i     (ack_i),
  .ready_o   (ready_o),
  .msg_len_o (msg_len_o),
  .status_o  (status_o),
  .swap_i    (swap),
  .busy_i    (rx_busy),
  .nonempty_i(buf_nonempty),
  .fill_sel_i(fill_sel)
);

// File: tb/tb_cmd_rx_top.sv
module tb_cmd_rx_top;

  localparam int TICK  = 4;
  localparam int OSR   = 16;
  localparam int GAP   = 1000;
  localparam int DEPTH = 16;
  localparam int BIT   = TICK * OSR;

  // {length, seed, pause in 100-cycle units, expected length}
  localparam logic [31:0] VEC [5] = '{
    {8'd1, 8'h10, 8'd0, 8'd1},
    {8'd4, 8'h33, 8'd2, 8'd4},
    {8'd7, 8'h7e, 8'd6, 8'd7},
    {8'd2, 8'hc1, 8'd0, 8'd2},
    {8'd8, 8'h05, 8'd3, 8'd8}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       ack = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ready;
  logic [4:0] msg_len;
  logic [3:0] status;

  int total = 0;
  int bad = 0;
  logic exp_bank = 1'b0;

  always #4 clk = ~clk;

  cmd_rx_top #(
    .CLK_PER_TICK(TICK),
    .OVERSAMPLE  (OSR),
    .GAP_CYCLES  (GAP),
    .BUF_DEPTH   (DEPTH)
  ) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .rx_i     (rx),
    .ack_i    (ack),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .ready_o  (ready),
    .msg_len_o(msg_len),
    .status_o (status)
  );

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return (seed + 8'(k * 37)) ^ 8'h5A;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic good_stop);
    rx = 1'b0;
    idle(BIT);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      idle(BIT);
    end
    if (good_stop) begin
      rx = 1'b1;
      idle(BIT);
    end else begin
      rx = 1'b0;
      idle(48);
      rx = 1'b1;
      idle(BIT);
    end
  endtask

  task automatic send_msg(input int n, input logic [7:0] seed, input int pause, input int bad_idx);
    for (int k = 0; k < n; k++) begin
      send_byte(pat(seed, k), k != bad_idx);
      if (k != n - 1) idle(pause);
    end
  endtask

  task automatic read_at(input int a, output logic [7:0] d);
    rd_addr = 4'(a);
    @(negedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    idle(10);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    check("R1 ready", ready, 0);
    check("R1 len", msg_len, 0);
    check("R1 status", status, 0);

    // R4: empty bank, idle line, no hand-over
    idle(2 * GAP);
    check("R4 ready on idle empty line", ready, 0);

    // R11: short low pulse rejected
    rx = 1'b0;
    idle(16);
    rx = 1'b1;
    idle(2 * GAP);
    check("R11 glitch no ready", ready, 0);
    send_msg(2, 8'h44, 0, -1);
    idle(GAP + 200);
    check("R11 ready", ready, 1);
    check("R11 len excludes glitch", msg_len, 2);
    read_at(0, d);
    check("R11 first byte", d, pat(8'h44, 0));
    check("R5 bank", status[2], exp_bank);
    exp_bank = ~exp_bank;
    do_ack();

    // table walk
    for (int v = 0; v < 5; v++) begin
      int n, pause, elen;
      logic [7:0] seed;
      n     = int'(VEC[v][31:24]);
      seed  = VEC[v][23:16];
      pause = int'(VEC[v][15:8]) * 100;
      elen  = int'(VEC[v][7:0]);
      send_msg(n, seed, pause, -1);
      idle(GAP / 2);
      check("R3 no ready before gap", ready, 0);
      idle(GAP - 300);
      check("R3 ready after gap", ready, 1);
      check("R6 length", msg_len, elen);
      check("R5 bank index", status[2], exp_bank);
      check("R8 no frame error", status[0], 0);
      check("R7 no overflow", status[1], 0);
      for (int k = 0; k < elen; k++) begin
        read_at(k, d);
        check("R2 data", d, pat(seed, k));
      end
      exp_bank = ~exp_bank;
      do_ack();
      check("R9 ready cleared", ready, 0);
    end

    // R8: bad stop bit in middle byte
    send_msg(3, 8'h91, 0, 1);
    idle(GAP + 200);
    check("R8 ready", ready, 1);
    check("R8 frame flag", status[0], 1);
    check("R8 byte kept len", msg_len, 3);
    read_at(1, d);
    check("R8 byte kept data", d, pat(8'h91, 1));
    exp_bank = ~exp_bank;
    do_ack();
    check("R9 frame flag cleared", status[0], 0);
    send_msg(1, 8'h22, 0, -1);
    idle(GAP + 200);
    check("R8 not carried over", status[0], 0);
    check("R5 bank after frame msg", status[2], exp_bank);
    exp_bank = ~exp_bank;
    do_ack();

    // R7: overflow
    send_msg(DEPTH + 3, 8'h60, 0, -1);
    idle(GAP + 200);
    check("R7 len capped", msg_len, DEPTH);
    check("R7 overflow flag", status[1], 1);
    read_at(0, d);
    check("R7 first byte", d, pat(8'h60, 0));
    read_at(DEPTH - 1, d);
    check("R7 last stored byte", d, pat(8'h60, DEPTH - 1));
    exp_bank = ~exp_bank;
    do_ack();
    check("R9 overflow cleared", status[1], 0);

    // R10: new message while previous unacknowledged
    send_msg(2, 8'hA0, 0, -1);
    idle(GAP + 200);
    check("R10 first ready", ready, 1);
    check("R10 no replace yet", status[3], 0);
    exp_bank = ~exp_bank;
    send_msg(3, 8'hB7, 0, -1);
    idle(GAP + 200);
    check("R10 replaced flag", status[3], 1);
    check("R10 new length", msg_len, 3);
    check("R10 bank", status[2], exp_bank);
    read_at(0, d);
    check("R10 new data", d, pat(8'hB7, 0));
    do_ack();
    check("R9 replaced cleared", status[3], 0);
    check("R9 ready low", ready, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule